// File: doc/BRIEF.md
# SFR Indirect-Access Bridge

This bridge lets an 8-bit microcontroller reach a peripheral that has a 9-bit register address and an 8-bit data path. The controller's external special-function-register port only offers a few byte-wide locations, so the peripheral is reached indirectly through a window of four consecutive SFR slots. Two slots build the peripheral address, one holds the byte to be written, and one returns the byte that was read. The controller, the bridge and the peripheral all run on one clock.

Firmware drives each transfer step by step. It loads the address and, for a write, the data byte. It then writes the control slot with a request bit set and polls the done bit in that same slot. For a read, it then fetches the byte from the read slot. The bridge turns each request into a single-cycle strobe on the peripheral side. It captures the peripheral's answer one cycle after a read strobe.

Top module: `sfr_bridge`

## Requirements
- R1: After reset all four window slots read back zero, and neither peripheral strobe is active.
- R2: The window base is 7-bit SFR address 0x40. A write to offset 0 (0x40) sets peripheral address bits [7:0]. Bit 0 of a write to offset 1 (0x41) sets peripheral address bit 8. Both values read back at their slots and appear on `per_addr`.
- R3: A write to offset 2 (0x42) only latches the data byte, which appears on `per_wdata` and reads back at 0x42. It issues no strobe.
- R4: Writing 0x41 with bit 2 set raises `per_wr` for exactly one cycle, in the cycle after the SFR write, with the current address and data byte.
- R5: Writing 0x41 with bit 1 set raises `per_rd` for exactly one cycle, in the cycle after the SFR write. The peripheral byte presented in the cycle after the strobe is captured into offset 3 (0x43), and done (bit 7 of 0x41) is set at that same edge.
- R6: When bits 1 and 2 are set together, the write strobe comes first and the read strobe follows in the next cycle. Done is set only once the read byte has been captured.
- R7: The request bits, read back at bits 1 and 2 of 0x41, clear by themselves once their strobe has been issued. Done is also set at the end of a write strobe that has no read pending.
- R8: Writing 0x41 with either request bit set clears done. A write to 0x41 with neither request bit set leaves done unchanged. Bits 3 to 7 of 0x41 cannot be written and read as zero, except for done in bit 7.
- R9: An SFR write outside 0x40 to 0x43 changes no state and issues no strobe. An SFR read outside that window returns zero.
- R10: `per_wr` and `per_rd` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 7 | External SFR address (MSB of the 8-bit SFR address removed) |
| sfr_wr | input | 1 | SFR write enable |
| sfr_rd | input | 1 | SFR read enable |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, combinational from address |
| per_addr | output | 9 | Peripheral register address |
| per_wdata | output | 8 | Peripheral write data |
| per_wr | output | 1 | Peripheral write strobe, one cycle |
| per_rd | output | 1 | Peripheral read strobe, one cycle |
| per_rdata | input | 8 | Peripheral read data, valid the cycle after `per_rd` |

## Verification
A strobe is due one clock edge after the SFR write to the control slot. When both request bits are set, the read strobe comes one edge later. The captured byte and done appear two edges after a lone read request and three edges after a combined request. The bench drives its inputs on falling edges and samples on falling edges. It waits that exact number of falling edges before it reads 0x41 or 0x43. A monitor compares each strobe against a queue of expected transfers in the cycle where the strobe appears, so a late, early, doubled or unexpected strobe is flagged.

// File: rtl/sfr_bridge.sv
module sfr_bridge #(
  parameter logic [6:0] BASE = 7'h40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic       sfr_rd,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  output logic [8:0] per_addr,
  output logic [7:0] per_wdata,
  output logic       per_wr,
  output logic       per_rd,
  input  logic [7:0] per_rdata
);
  localparam logic [1:0] OFS_ALO = 2'd0;
  localparam logic [1:0] OFS_CTL = 2'd1;
  localparam logic [1:0] OFS_WD  = 2'd2;

  logic [7:0] addr_lo, wdata_q, rdata_q;
  logic       addr_hi, rd_req, wr_req, cap, done_q;

  wire hit = (sfr_addr[6:2] == BASE[6:2]);
  wire [1:0] ofs = sfr_addr[1:0];

  assign per_addr  = {addr_hi, addr_lo};
  assign per_wdata = wdata_q;
  assign per_wr    = wr_req;
  assign per_rd    = rd_req & ~wr_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo <= '0;
      addr_hi <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      rd_req  <= 1'b0;
      wr_req  <= 1'b0;
      cap     <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (wr_req)      wr_req <= 1'b0;
      else if (rd_req) rd_req <= 1'b0;
      cap <= per_rd;
      if (cap) begin
        rdata_q <= per_rdata;
        done_q  <= 1'b1;
      end
      if (wr_req && !rd_req) done_q <= 1'b1;
      if (sfr_wr && hit) begin
        case (ofs)
          OFS_ALO: addr_lo <= sfr_wdata;
          OFS_CTL: begin
            addr_hi <= sfr_wdata[0];
            if (sfr_wdata[1]) rd_req <= 1'b1;
            if (sfr_wdata[2]) wr_req <= 1'b1;
            if (sfr_wdata[1] || sfr_wdata[2]) done_q <= 1'b0;
          end
          OFS_WD:  wdata_q <= sfr_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    sfr_rdata = '0;
    if (sfr_rd && hit) begin
      case (ofs)
        OFS_ALO: sfr_rdata = addr_lo;
        OFS_CTL: sfr_rdata = {done_q, 4'b0, wr_req, rd_req, addr_hi};
        OFS_WD:  sfr_rdata = wdata_q;
        default: sfr_rdata = rdata_q;
      endcase
    end
  end
endmodule

// File: rtl/sfr_bridge_chk.sv
module sfr_bridge_chk #(
  parameter logic [6:0] BASE = 7'h40
) (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] sfr_addr,
  input logic       sfr_wr,
  input logic       sfr_rd,
  input logic [7:0] sfr_wdata,
  input logic [7:0] sfr_rdata,
  input logic [8:0] per_addr,
  input logic       per_wr,
  input logic       per_rd,
  input logic       done
);
  localparam logic [6:0] CTL = BASE + 7'd1;
  wire win  = (sfr_addr[6:2] == BASE[6:2]);
  wire actl = sfr_wr && (sfr_addr == CTL);
  wire addr_w = sfr_wr && win && (sfr_addr[1] == 1'b0);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_wr && per_rd));

  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wr && !(actl && sfr_wdata[2])) |=> !per_wr);

  assert_rd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (per_rd && !(actl && (sfr_wdata[1] || sfr_wdata[2]))) |=> !per_rd);

  assert_outside_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd && !win) |-> (sfr_rdata == 8'h00));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_w |=> $stable(per_addr));

  assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (actl && (sfr_wdata[1] || sfr_wdata[2])) |=> !done);
endmodule

bind sfr_bridge sfr_bridge_chk #(.BASE(BASE)) chk (
  .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
  .sfr_rd(sfr_rd), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
  .per_addr(per_addr), .per_wr(per_wr), .per_rd(per_rd), .done(done_q)
);

// File: tb/sfr_bridge_test.sv
module sfr_bridge_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] sfr_addr = '0;
  logic       sfr_wr = 1'b0;
  logic       sfr_rd = 1'b0;
  logic [7:0] sfr_wdata = '0;
  logic [7:0] sfr_rdata;
  logic [8:0] per_addr;
  logic [7:0] per_wdata;
  logic       per_wr, per_rd;
  logic [7:0] per_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sfr_bridge uut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_rd(sfr_rd), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_wr(per_wr),
    .per_rd(per_rd), .per_rdata(per_rdata)
  );

  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];
  logic [7:0] prd_q = '0;
  assign per_rdata = prd_q;

  initial for (int i = 0; i < 512; i++) begin
    mem[i] = 8'((i * 7) + 3);
    exp_mem[i] = 8'((i * 7) + 3);
  end

  always @(posedge clk) begin
    if (per_wr) mem[per_addr] <= per_wdata;
    if (per_rd) prd_q <= mem[per_addr];
  end

  typedef struct packed { logic is_wr; logic [8:0] a; logic [7:0] d; } item_t;
  item_t exp_q[$];

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (per_wr && per_rd) check("R10 both strobes", 16'd1, 16'd0);
      if (per_wr || per_rd) begin
        if (exp_q.size() == 0) check("R4/R5 unexpected strobe", {per_wr, per_rd}, 16'd0);
        else begin
          item_t it;
          it = exp_q.pop_front();
          check(it.is_wr ? "R4 strobe kind" : "R5 strobe kind", {15'd0, per_wr}, {15'd0, it.is_wr});
          check("R4/R5 strobe addr", {7'd0, per_addr}, {7'd0, it.a});
          if (it.is_wr) check("R4 strobe data", {8'd0, per_wdata}, {8'd0, it.d});
        end
      end
    end
  end

  task automatic sfr_write(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic sfr_check(input string req, input logic [6:0] a, input logic [7:0] exp);
    sfr_addr = a; sfr_rd = 1'b1;
    #1;
    check(req, {8'd0, sfr_rdata}, {8'd0, exp});
    sfr_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [8:0] a, input logic [7:0] d);
    sfr_write(7'h40, a[7:0]);
    sfr_write(7'h42, d);
    exp_q.push_back({1'b1, a, d});
    exp_mem[a] = d;
    sfr_write(7'h41, {5'd0, 2'b10, a[8]});
    wait_cyc(1);
    sfr_check("R7 write done", 7'h41, {7'h40, a[8]});
  endtask

  task automatic do_read(input logic [8:0] a);
    sfr_write(7'h40, a[7:0]);
    exp_q.push_back({1'b0, a, 8'h00});
    sfr_write(7'h41, {5'd0, 2'b01, a[8]});
    wait_cyc(2);
    sfr_check("R5 read data", 7'h43, exp_mem[a]);
    sfr_check("R5 read done", 7'h41, {7'h40, a[8]});
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    for (int i = 0; i < 4; i++) sfr_check("R1 reset slot", 7'(7'h40 + i), 8'h00);
    check("R1 no strobe", {per_wr, per_rd}, 16'd0);

    sfr_write(7'h40, 8'h5A);
    sfr_write(7'h41, 8'h01);
    sfr_check("R2 addr lo", 7'h40, 8'h5A);
    sfr_check("R2 addr hi", 7'h41, 8'h01);
    check("R2 per_addr", {7'd0, per_addr}, 16'h015A);

    sfr_write(7'h42, 8'hC3);
    wait_cyc(1);
    sfr_check("R3 wdata", 7'h42, 8'hC3);
    check("R3 per_wdata", {8'd0, per_wdata}, 16'h00C3);

    exp_q.push_back({1'b1, 9'h15A, 8'hC3});
    exp_mem[9'h15A] = 8'hC3;
    sfr_write(7'h41, 8'h05);
    sfr_check("R7 wr pending", 7'h41, 8'h05);
    wait_cyc(1);
    sfr_check("R7 wr cleared done", 7'h41, 8'h81);

    exp_q.push_back({1'b0, 9'h15A, 8'h00});
    sfr_write(7'h41, 8'h03);
    sfr_check("R8 done cleared", 7'h41, 8'h03);
    wait_cyc(2);
    sfr_check("R5 captured", 7'h43, 8'hC3);
    sfr_check("R5 done", 7'h41, 8'h81);

    sfr_write(7'h41, 8'hF8);
    sfr_check("R8 no-req write keeps done", 7'h41, 8'h80);

    do_read(9'h023);

    sfr_write(7'h40, 8'h77);
    sfr_write(7'h42, 8'h9E);
    exp_q.push_back({1'b1, 9'h077, 8'h9E});
    exp_q.push_back({1'b0, 9'h077, 8'h00});
    exp_mem[9'h077] = 8'h9E;
    sfr_write(7'h41, 8'h06);
    sfr_check("R6 both pending", 7'h41, 8'h06);
    wait_cyc(1);
    sfr_check("R6 no early done", 7'h41, 8'h02);
    wait_cyc(2);
    sfr_check("R6 read after write", 7'h43, 8'h9E);
    sfr_check("R6 done", 7'h41, 8'h80);

    sfr_write(7'h44, 8'hFF);
    sfr_write(7'h3C, 8'hFF);
    sfr_write(7'h00, 8'h06);
    sfr_write(7'h7D, 8'h06);
    wait_cyc(3);
    sfr_check("R9 outside read", 7'h44, 8'h00);
    sfr_check("R9 outside read", 7'h3F, 8'h00);
    sfr_check("R9 addr untouched", 7'h40, 8'h77);
    sfr_check("R9 ctl untouched", 7'h41, 8'h80);
    sfr_check("R9 wdata untouched", 7'h42, 8'h9E);
    check("R9 no strobe", 16'(exp_q.size()), 16'd0);

    for (int k = 0; k < 12; k++) begin
      logic [8:0] a;
      a = 9'((k * 37 + 5) % 512);
      do_write(a, 8'((k * 29) ^ 8'hA5));
      do_read(a);
      do_read(9'(a + 9'd200));
    end

    wait_cyc(2);
    check("R4/R5 all strobes seen", 16'(exp_q.size()), 16'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule